// File: doc/BRIEF.md
# PLL Dynamic Frequency-Update Handshake Controller

This controller lets software retune a running PLL without stopping it. Software stores a new integer multiplier and a new fractional value in their registers. It then sets the update-request bit in the mode register. The controller drives that request to the PLL core as a latch strobe, together with a snapshot of the multiplier and the fractional value. It then follows the core's latch acknowledge as it rises and falls. The fractional value reaches the core only when the fractional-enable bit in the user-control register is set. Otherwise the core receives zero in that field.

Two release modes exist. In the default mode, the hardware drops the request by itself in the clock step where it first accepts the acknowledge. In bypass mode, the request stays high until software writes it back to 0. In both modes, the acknowledge is ignored for a guard window of two reference cycles after the request rises. The update counts as finished only once the acknowledge has risen and then fallen. A programmable timeout watches both waits. If either one runs out, a sticky error flag is raised.

Requests are accepted only when the PLL-enable bit was already set and the dynamic-update parameter is on. In any other case, the written values are just stored.

Top module: `pll_dynupd_ctrl`

## Requirements
- R1: After reset, every register reads 0 except the timeout limit, which reads its reset parameter (default 1000). `core_latch`, `core_l` and `core_alpha` are all 0.
- R2: Register map: address 0 is the mode register, 1 is the multiplier, 2 is the fractional value, 3 is user control (bit 0 = fractional enable) and 4 is the timeout limit. The multiplier, fractional and limit registers read back what was written.
- R3: Mode register fields: bit 0 = PLL enable (read/write), bit 22 = update request, bit 23 = bypass (read/write), bit 24 = timeout error (write 1 to clear), bit 25 = update done, bit 29 = latch-acknowledge status, bit 30 = active (reflects bit 0). All other bits read 0.
- R4: A write of 1 to bit 22 starts an update only if bit 0 was already 1, the controller is idle and DYN_UPDATE is 1. Otherwise bit 22 and `core_latch` stay 0.
- R5: `core_latch` always equals mode bit 22. `core_l` and `core_alpha` are captured in the clock step that accepts the request, and they stay stable until the update ends, even if the registers are rewritten in the meantime.
- R6: For GUARD_CYC (2) clock steps after the request is accepted, the acknowledge is ignored and mode bit 29 reads 0.
- R7: With bypass at 0, the request clears at the clock edge where the acknowledge is first accepted.
- R8: With bypass at 1, the request stays set after the acknowledge until software writes bit 22 to 0.
- R9: Done (bit 25) is set only after the acknowledge has risen and then fallen. It clears when the next request is accepted.
- R10: `core_alpha` is 0 when the fractional enable was 0 at acceptance. When it was 1, `core_alpha` carries the fractional register.
- R11: If the acknowledge does not rise, or does not fall after the request is released, within the limit number of cycles, error bit 24 is set and the request is dropped. The error stays set until software writes 1 to bit 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| core_latch | output | 1 | Latch strobe to the PLL core |
| core_l | output | L_W | Captured multiplier presented to the core |
| core_alpha | output | A_W | Captured fractional value presented to the core |
| core_ack | input | 1 | Latch acknowledge from the PLL core |

## Verification
The assertions assume the core's acknowledge is synchronous to `clk` and rises only while the latch strobe is high. They also assume the bypass bit is left unchanged while an update is in flight. The bench core model meets both conditions: it raises the acknowledge a fixed number of cycles after the strobe rises and drops it a fixed number of cycles after the strobe falls. It can also be told to stay silent, which exercises the timeout. Software writes from the bench repeat the enable and bypass values they found, so no update sees its mode change midway.

// File: rtl/pll_upd_pkg.sv
package pll_upd_pkg;

  localparam int MB_EN     = 0;
  localparam int MB_REQ    = 22;
  localparam int MB_BYP    = 23;
  localparam int MB_ERR    = 24;
  localparam int MB_DONE   = 25;
  localparam int MB_ACK    = 29;
  localparam int MB_ACTIVE = 30;

  typedef enum logic [2:0] {
    RA_MODE = 3'd0,
    RA_LVAL = 3'd1,
    RA_FRAC = 3'd2,
    RA_USER = 3'd3,
    RA_TMO  = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GUARD,
    ST_RISE,
    ST_FALL
  } upd_state_e;

  function automatic logic [31:0] mode_word(input logic en, input logic req,
                                            input logic byp, input logic err,
                                            input logic done, input logic ack);
    logic [31:0] w;
    w = '0;
    w[MB_EN]     = en;
    w[MB_REQ]    = req;
    w[MB_BYP]    = byp;
    w[MB_ERR]    = err;
    w[MB_DONE]   = done;
    w[MB_ACK]    = ack;
    w[MB_ACTIVE] = en;
    return w;
  endfunction

  function automatic logic [31:0] frac_gate(input logic [31:0] frac, input logic use_frac);
    return use_frac ? frac : 32'd0;
  endfunction

endpackage

// File: rtl/pll_upd_regs.sv
module pll_upd_regs
  import pll_upd_pkg::*;
#(
  parameter int L_W     = 16,
  parameter int A_W     = 32,
  parameter int TO_W    = 16,
  parameter int TMO_RST = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [2:0]      addr,
  input  logic [31:0]     wdata,
  output logic            en_q,
  output logic            byp_q,
  output logic            frac_en_q,
  output logic [L_W-1:0]  l_q,
  output logic [A_W-1:0]  a_q,
  output logic [TO_W-1:0] tmo_q
);

  logic unused_wd;
  assign unused_wd = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      byp_q     <= 1'b0;
      frac_en_q <= 1'b0;
      l_q       <= '0;
      a_q       <= '0;
      tmo_q     <= TO_W'(TMO_RST);
    end else if (wr) begin
      case (reg_addr_e'(addr))
        RA_MODE: begin
          en_q  <= wdata[MB_EN];
          byp_q <= wdata[MB_BYP];
        end
        RA_LVAL: l_q       <= wdata[L_W-1:0];
        RA_FRAC: a_q       <= wdata[A_W-1:0];
        RA_USER: frac_en_q <= wdata[0];
        RA_TMO:  tmo_q     <= wdata[TO_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pll_upd_fsm.sv
module pll_upd_fsm
  import pll_upd_pkg::*;
#(
  parameter int TO_W      = 16,
  parameter int GUARD_CYC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_req1,
  input  logic            wr_req0,
  input  logic            allow,
  input  logic            byp,
  input  logic            err_clr,
  input  logic            core_ack,
  input  logic [TO_W-1:0] tmo_lim,
  output logic            req_q,
  output logic            done_q,
  output logic            err_q,
  output logic            start,
  output logic            busy,
  output logic            guard_act,
  output logic            ack_vis,
  output logic            ack_seen,
  output logic            ack_gone,
  output logic            sw_clr,
  output logic            timeout
);

  localparam int GW = (GUARD_CYC < 2) ? 1 : $clog2(GUARD_CYC);

  upd_state_e      st;
  logic [GW-1:0]   gcnt;
  logic [TO_W-1:0] tcnt;
  logic            cnt_on;

  assign busy      = (st != ST_IDLE);
  assign guard_act = (st == ST_GUARD);
  assign start     = wr_req1 && allow && (st == ST_IDLE);
  assign ack_vis   = core_ack && !guard_act;
  assign ack_seen  = (st == ST_RISE) && core_ack;
  assign ack_gone  = (st == ST_FALL) && !req_q && !core_ack;
  assign sw_clr    = (st == ST_FALL) && req_q && byp && wr_req0;
  assign cnt_on    = (st == ST_RISE) || ((st == ST_FALL) && !req_q);
  assign timeout   = cnt_on && (tcnt == tmo_lim) && !ack_seen && !ack_gone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      gcnt   <= '0;
      tcnt   <= '0;
      req_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (err_clr) err_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          req_q  <= 1'b1;
          done_q <= 1'b0;
          gcnt   <= '0;
          st     <= ST_GUARD;
        end
        ST_GUARD: begin
          if (gcnt == GW'(GUARD_CYC - 1)) begin
            tcnt <= '0;
            st   <= ST_RISE;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        ST_RISE: begin
          if (ack_seen) begin
            tcnt <= '0;
            st   <= ST_FALL;
            if (!byp) req_q <= 1'b0;
          end else if (timeout) begin
            err_q <= 1'b1;
            req_q <= 1'b0;
            st    <= ST_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_FALL: begin
          if (sw_clr) req_q <= 1'b0;
          if (ack_gone) begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else if (timeout) begin
            err_q <= 1'b1;
            req_q <= 1'b0;
            st    <= ST_IDLE;
          end else if (cnt_on) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_dynupd_ctrl.sv
module pll_dynupd_ctrl
  import pll_upd_pkg::*;
#(
  parameter int L_W        = 16,
  parameter int A_W        = 32,
  parameter int TO_W       = 16,
  parameter int TMO_RST    = 1000,
  parameter int GUARD_CYC  = 2,
  parameter bit DYN_UPDATE = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           core_latch,
  output logic [L_W-1:0] core_l,
  output logic [A_W-1:0] core_alpha,
  input  logic           core_ack
);

  logic            en_q, byp_q, frac_en_q;
  logic [L_W-1:0]  l_q;
  logic [A_W-1:0]  a_q;
  logic [TO_W-1:0] tmo_q;
  logic            mode_wr;
  logic            req_q, done_q, err_q;
  logic            start, busy, guard_act, ack_vis, ack_seen, ack_gone, sw_clr, timeout;

  assign mode_wr = reg_wr && (reg_addr == RA_MODE);

  pll_upd_regs #(.L_W(L_W), .A_W(A_W), .TO_W(TO_W), .TMO_RST(TMO_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .en_q(en_q), .byp_q(byp_q), .frac_en_q(frac_en_q),
    .l_q(l_q), .a_q(a_q), .tmo_q(tmo_q)
  );

  pll_upd_fsm #(.TO_W(TO_W), .GUARD_CYC(GUARD_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .wr_req1(mode_wr && reg_wdata[MB_REQ]),
    .wr_req0(mode_wr && !reg_wdata[MB_REQ]),
    .allow(en_q && DYN_UPDATE),
    .byp(byp_q),
    .err_clr(mode_wr && reg_wdata[MB_ERR]),
    .core_ack(core_ack), .tmo_lim(tmo_q),
    .req_q(req_q), .done_q(done_q), .err_q(err_q),
    .start(start), .busy(busy), .guard_act(guard_act),
    .ack_vis(ack_vis), .ack_seen(ack_seen), .ack_gone(ack_gone),
    .sw_clr(sw_clr), .timeout(timeout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_l     <= '0;
      core_alpha <= '0;
    end else if (start) begin
      core_l     <= l_q;
      core_alpha <= A_W'(frac_gate(32'(a_q), frac_en_q));
    end
  end

  assign core_latch = req_q;

  always_comb begin
    case (reg_addr_e'(reg_addr))
      RA_MODE: reg_rdata = mode_word(en_q, req_q, byp_q, err_q, done_q, ack_vis);
      RA_LVAL: reg_rdata = 32'(l_q);
      RA_FRAC: reg_rdata = 32'(a_q);
      RA_USER: reg_rdata = {31'd0, frac_en_q};
      RA_TMO:  reg_rdata = 32'(tmo_q);
      default: reg_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/pll_dynupd_chk.sv
module pll_dynupd_chk #(
  parameter int L_W = 16,
  parameter int A_W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           core_latch,
  input logic [L_W-1:0] core_l,
  input logic [A_W-1:0] core_alpha,
  input logic           busy,
  input logic           guard_act,
  input logic           ack_vis,
  input logic           ack_seen,
  input logic           byp_q,
  input logic           sw_clr,
  input logic           timeout,
  input logic           err_q,
  input logic           err_clr
);

  p_guard_hides_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    guard_act |-> !ack_vis && !ack_seen);

  p_autoclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_seen && !byp_q) |=> !core_latch);

  p_bypass_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_latch && byp_q && busy && !guard_act && !ack_seen && !sw_clr && !timeout
     && $past(ack_seen)) |=> core_latch);

  p_capture_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(core_l) && $stable(core_alpha)));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);

  p_latch_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !core_latch);

endmodule

bind pll_dynupd_ctrl pll_dynupd_chk #(.L_W(L_W), .A_W(A_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_latch(core_latch), .core_l(core_l),
  .core_alpha(core_alpha), .busy(busy), .guard_act(guard_act), .ack_vis(ack_vis),
  .ack_seen(ack_seen), .byp_q(byp_q), .sw_clr(sw_clr), .timeout(timeout),
  .err_q(err_q), .err_clr(mode_wr && reg_wdata[24])
);

// File: tb/pll_dynupd_ctrl_tb.sv
module pll_dynupd_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BIT_EN = 0, BIT_REQ = 22, BIT_BYP = 23, BIT_ERR = 24;
  localparam int BIT_DONE = 25, BIT_ACK = 29, BIT_ACT = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        core_latch;
  logic [15:0] core_l;
  logic [31:0] core_alpha;
  logic        model_ack;

  int n_chk = 0;
  int n_bad = 0;
  int up_dly = 3;
  int dn_dly = 2;
  bit dead = 1'b0;
  int cu = 0;
  int cd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_dynupd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_latch(core_latch),
    .core_l(core_l), .core_alpha(core_alpha), .core_ack(model_ack)
  );

  // PLL core stand-in: ack follows the latch strobe after fixed delays
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_ack <= 1'b0;
      cu = 0;
      cd = 0;
    end else if (!model_ack) begin
      cd = 0;
      if (core_latch && !dead) begin
        cu = cu + 1;
        if (cu >= up_dly) begin
          model_ack <= 1'b1;
          cu = 0;
        end
      end else cu = 0;
    end else begin
      cu = 0;
      if (!core_latch) begin
        cd = cd + 1;
        if (cd >= dn_dly) begin
          model_ack <= 1'b0;
          cd = 0;
        end
      end else cd = 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] mbits(input bit en, input bit req, input bit byp,
                                        input bit err, input bit done, input bit ack);
    return (32'(en) << BIT_EN) | (32'(req) << BIT_REQ) | (32'(byp) << BIT_BYP) |
           (32'(err) << BIT_ERR) | (32'(done) << BIT_DONE) | (32'(ack) << BIT_ACK) |
           (32'(en) << BIT_ACT);
  endfunction

  task automatic wait_ack(input logic lvl);
    for (int i = 0; i < 100 && model_ack !== lvl; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); check("R1 mode after reset", d, 32'd0);
    rd(3'd4, d); check("R1 limit after reset", d, 32'd1000);
    check("R1 latch after reset", 32'(core_latch), 32'd0);
    check("R1 core_l after reset", 32'(core_l), 32'd0);
  endtask

  task automatic t_regs_store_only();
    logic [31:0] d;
    wr(3'd1, 32'h0000_00A5);
    wr(3'd2, 32'h0001_2345);
    wr(3'd4, 32'd40);
    rd(3'd1, d); check("R2 L readback", d, 32'h0000_00A5);
    rd(3'd2, d); check("R2 frac readback", d, 32'h0001_2345);
    rd(3'd4, d); check("R2 limit readback", d, 32'd40);
    wr(3'd0, 32'(1) << BIT_REQ);
    repeat (4) @(negedge clk);
    check("R4 no latch when disabled", 32'(core_latch), 32'd0);
    rd(3'd0, d); check("R4 req bit stays 0 when disabled", d, 32'd0);
    check("R4 core_l not passed", 32'(core_l), 32'd0);
  endtask

  task automatic t_auto_clear();
    logic [31:0] d;
    wr(3'd3, 32'd1);
    wr(3'd1, 32'h0000_1234);
    wr(3'd2, 32'h000A_BCDE);
    wr(3'd0, mbits(1, 0, 0, 0, 0, 0));
    rd(3'd0, d); check("R3 enable/active bits", d, mbits(1, 0, 0, 0, 0, 0));
    wr(3'd0, mbits(1, 1, 0, 0, 0, 0));
    check("R5 latch follows request", 32'(core_latch), 32'd1);
    check("R5 core_l captured", 32'(core_l), 32'h0000_1234);
    check("R10 frac passed when enabled", core_alpha, 32'h000A_BCDE);
    wr(3'd1, 32'h0000_7777);
    check("R5 core_l stable during update", 32'(core_l), 32'h0000_1234);
    wait_ack(1'b1);
    check("R7 latch high when ack first seen", 32'(core_latch), 32'd1);
    @(negedge clk);
    check("R7 latch auto-cleared", 32'(core_latch), 32'd0);
    rd(3'd0, d); check("R7 req bit cleared, ack shown", d, mbits(1, 0, 0, 0, 0, 1));
    wait_ack(1'b0);
    rd(3'd0, d); check("R9 not done before ack fall seen", d[BIT_DONE], 32'd0);
    @(negedge clk);
    rd(3'd0, d); check("R9 done after ack fall", d, mbits(1, 0, 0, 0, 1, 0));
  endtask

  task automatic t_bypass();
    logic [31:0] d;
    wr(3'd0, mbits(1, 1, 1, 0, 0, 0));
    rd(3'd0, d); check("R9 done cleared on new request", d[BIT_DONE], 32'd0);
    check("R5 new L captured", 32'(core_l), 32'h0000_7777);
    wait_ack(1'b1);
    repeat (5) @(negedge clk);
    check("R8 latch held in bypass", 32'(core_latch), 32'd1);
    rd(3'd0, d); check("R8 mode while held", d, mbits(1, 1, 1, 0, 0, 1));
    wr(3'd0, mbits(1, 0, 1, 0, 0, 0));
    check("R8 software release", 32'(core_latch), 32'd0);
    wait_ack(1'b0);
    @(negedge clk);
    rd(3'd0, d); check("R9 done in bypass", d, mbits(1, 0, 1, 0, 1, 0));
    wr(3'd0, mbits(1, 0, 0, 0, 0, 0));
  endtask

  task automatic t_guard_and_frac_off();
    logic [31:0] d;
    int n;
    up_dly = 1;
    wr(3'd3, 32'd0);
    wr(3'd0, mbits(1, 1, 0, 0, 0, 0));
    check("R10 frac zero when disabled", core_alpha, 32'd0);
    @(negedge clk);
    check("R6 model ack early", 32'(model_ack), 32'd1);
    rd(3'd0, d); check("R6 ack hidden in guard", d[BIT_ACK], 32'd0);
    n = 2;
    @(negedge clk);
    while (core_latch && n < 50) begin n++; @(negedge clk); end
    check("R6 latch high cycles with early ack", 32'(n), 32'd3);
    wait_ack(1'b0);
    @(negedge clk);
    up_dly = 3;
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    dead = 1'b1;
    wr(3'd4, 32'd10);
    wr(3'd0, mbits(1, 1, 0, 0, 0, 0));
    repeat (8) @(negedge clk);
    rd(3'd0, d); check("R11 no error before limit", d[BIT_ERR], 32'd0);
    repeat (12) @(negedge clk);
    rd(3'd0, d); check("R11 error and request dropped", d, mbits(1, 0, 0, 1, 0, 0));
    repeat (3) @(negedge clk);
    rd(3'd0, d); check("R11 error sticky", d[BIT_ERR], 32'd1);
    wr(3'd0, mbits(1, 0, 0, 1, 0, 0));
    rd(3'd0, d); check("R11 error cleared by write 1", d, mbits(1, 0, 0, 0, 0, 0));
    dead = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs_store_only();
    t_auto_clear();
    t_bypass();
    t_guard_and_frac_off();
    t_timeout();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule